// File: doc/BRIEF.md
# Converter Audio Source Router

This block picks the sample source for an on-chip audio converter. The source is either the decoder's parallel stereo samples or an external serial stream. A 4-bit routing code selects the source. When the code is 0000 the block is in loopback. The external serial output drivers are enabled, and a serial receiver turns a stream from outside into stereo samples. That stream arrives on its own bit clock, data and word clock pins. Every other code selects internal routing. Decoder samples then pass straight to the converter, and the serial output drivers are held in high impedance.

The receiver always works with 16-bit words, one stereo frame per sample period, and takes the most significant bit first. Its framing style follows the output format code. The I2S-style codes select I2S framing, and all other codes select a word-clock-aligned framing. For each complete frame the receiver raises a one-cycle valid pulse to the converter. A controlling state machine has three states. ST_INTERNAL holds the receiver cleared. ST_HUNT waits for a complete left word. ST_HAVE_LEFT waits for the matching right word. The transitions are: ST_INTERNAL to ST_HUNT when loopback is selected; ST_HUNT to ST_HAVE_LEFT on a completed left word; ST_HAVE_LEFT to ST_HUNT on a completed right word, which emits the frame; ST_HAVE_LEFT stays in place on another left word and replaces the held one; any state goes to ST_INTERNAL when loopback is left. The block also checks the format code against internal routing.

Top module: `audio_src_router`

## Requirements
- R1: With any routing code other than 0000, ser_out_en is 0. A decoder sample presented with dec_valid appears on conv_left/conv_right with conv_valid high exactly one clock later, provided cfg_err is 0.
- R2: With routing code 0000, ser_out_en is 1 one clock after the code is applied, and dec_valid pulses produce no conv_valid.
- R3: With internal routing, activity on ser_bclk, ser_data and ser_wclk produces no conv_valid.
- R4: cfg_err is registered. It is 1 exactly when the routing code is not 0000 and the format code is none of 1010, 1011, 1110 and 0010. While cfg_err is 1, decoder samples produce no conv_valid.
- R5: The receiver samples ser_data and ser_wclk on the rising edge of ser_bclk and takes 16-bit words MSB first. Format codes 1010, 1110, 1100 and 1111 select I2S framing: ser_wclk low marks the left word, and its MSB comes one bit clock after the ser_wclk change. All other codes select aligned framing: ser_wclk high marks the left word, and its MSB comes on the first rising edge after the change.
- R6: Each complete left-then-right frame produces one conv_valid pulse of a single clock. conv_left and conv_right carry the frame and hold it until the next sample.
- R7: After loopback is entered, a frame already in progress is discarded. Output starts with the first complete frame.
- R8: A word counts only when 16 bits follow a word clock change with no further change. A truncated right word is dropped, and a left word that follows a held left word replaces it.
- R9: During and after reset, conv_left, conv_right, conv_valid, ser_out_en and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_code | input | 4 | Routing code, 0000 selects loopback |
| fmt_code | input | 4 | Serial output format code |
| dec_left | input | 16 | Decoder left sample |
| dec_right | input | 16 | Decoder right sample |
| dec_valid | input | 1 | Decoder sample strobe |
| ser_bclk | input | 1 | External serial bit clock |
| ser_data | input | 1 | External serial data |
| ser_wclk | input | 1 | External serial word clock |
| conv_left | output | 16 | Left sample to the converter |
| conv_right | output | 16 | Right sample to the converter |
| conv_valid | output | 1 | One-cycle sample strobe to the converter |
| ser_out_en | output | 1 | Enable for the external serial output drivers |
| cfg_err | output | 1 | Format code incompatible with internal routing |

## Verification
The hardest case is a receiver that enters a stream part way through a frame. This must not leak a frame built from stale or partial bits. Fragments left over from the previous stream make it harder still. The stimulus starts every loopback stream at a random bit position after the frame start, in both framing styles and on top of whatever the previous stream left behind. It then checks that only the complete frames that follow come out. A directed stream with a truncated right word forces a held left word to be replaced.

// File: rtl/audio_route_pkg.sv
package audio_route_pkg;

    localparam logic [3:0] ROUTE_LOOPBACK = 4'b0000;

    typedef enum logic [1:0] {
        ST_INTERNAL  = 2'd0,
        ST_HUNT      = 2'd1,
        ST_HAVE_LEFT = 2'd2
    } rtr_state_t;

    // Output formats that carry 16-bit words once per sample period
    function automatic logic fmt_is_single_rate16(input logic [3:0] f);
        return (f == 4'b1010) || (f == 4'b1011) || (f == 4'b1110) || (f == 4'b0010);
    endfunction

    // Output formats using I2S framing; the receiver copies this style
    function automatic logic fmt_is_i2s(input logic [3:0] f);
        return (f == 4'b1010) || (f == 4'b1110) || (f == 4'b1100) || (f == 4'b1111);
    endfunction

endpackage

// File: rtl/ars_route_decode.sv
module ars_route_decode
    import audio_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] route_code,
    input  logic [3:0] fmt_code,
    output logic       loop_q,
    output logic       style_i2s_q,
    output logic       cfg_err_q
);

    logic loop_d;

    assign loop_d = (route_code == ROUTE_LOOPBACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loop_q      <= 1'b0;
            style_i2s_q <= 1'b0;
            cfg_err_q   <= 1'b0;
        end else begin
            loop_q      <= loop_d;
            style_i2s_q <= fmt_is_i2s(fmt_code);
            cfg_err_q   <= !loop_d && !fmt_is_single_rate16(fmt_code);
        end
    end

endmodule

// File: rtl/ars_serial_rx.sv
module ars_serial_rx #(
    parameter int WORD_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 style_i2s,
    input  logic                 ser_bclk,
    input  logic                 ser_data,
    input  logic                 ser_wclk,
    output logic                 word_done,
    output logic                 word_left,
    output logic [WORD_BITS-1:0] word_data
);

    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam int PIN_N = 3;

    // stage vectors carry {wclk, data, bclk}
    logic [PIN_N-1:0] sync_q [SYNC_STAGES];

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= '0;
            end else if (g == 0) begin
                sync_q[g] <= {ser_wclk, ser_data, ser_bclk};
            end else begin
                sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
            end
        end
    end

    logic bclk_s, data_s, wclk_s, bclk_prev;
    logic bclk_rise;
    logic wc_p1, wc_p2;
    logic boundary, chan_left;
    logic armed, cur_left;
    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_BITS-1:0] shreg;

    assign {wclk_s, data_s, bclk_s} = sync_q[SYNC_STAGES-1];
    assign bclk_rise = bclk_s && !bclk_prev;
    // I2S words start one bit clock after the word clock changes
    assign boundary  = style_i2s ? (wc_p1 != wc_p2) : (wclk_s != wc_p1);
    assign chan_left = style_i2s ? !wc_p1 : wclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_prev <= 1'b0;
            wc_p1     <= 1'b0;
            wc_p2     <= 1'b0;
        end else begin
            bclk_prev <= bclk_s;
            if (bclk_rise) begin
                wc_p1 <= wclk_s;
                wc_p2 <= wc_p1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            cur_left  <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_done <= 1'b0;
            word_left <= 1'b0;
            word_data <= '0;
        end else begin
            word_done <= 1'b0;
            if (clear) begin
                armed   <= 1'b0;
                bit_cnt <= '0;
            end else if (bclk_rise) begin
                if (boundary) begin
                    armed    <= 1'b1;
                    cur_left <= chan_left;
                    bit_cnt  <= CNT_W'(1);
                    shreg    <= {{(WORD_BITS-1){1'b0}}, data_s};
                end else if (armed) begin
                    shreg <= {shreg[WORD_BITS-2:0], data_s};
                    if (bit_cnt == CNT_W'(WORD_BITS - 1)) begin
                        word_done <= 1'b1;
                        word_left <= cur_left;
                        word_data <= {shreg[WORD_BITS-2:0], data_s};
                        armed     <= 1'b0;
                        bit_cnt   <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ars_frame_ctrl.sv
module ars_frame_ctrl
    import audio_route_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 loop_q,
    input  logic                 cfg_err_q,
    input  logic [WORD_BITS-1:0] dec_left,
    input  logic [WORD_BITS-1:0] dec_right,
    input  logic                 dec_valid,
    input  logic                 word_done,
    input  logic                 word_left,
    input  logic [WORD_BITS-1:0] word_data,
    output logic [WORD_BITS-1:0] conv_left,
    output logic [WORD_BITS-1:0] conv_right,
    output logic                 conv_valid,
    output logic                 rx_clear,
    output rtr_state_t           state
);

    rtr_state_t           state_nx;
    logic [WORD_BITS-1:0] left_hold;
    logic                 got_left, got_right;

    assign got_left  = word_done && word_left;
    assign got_right = word_done && !word_left;
    assign rx_clear  = (state == ST_INTERNAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_INTERNAL;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INTERNAL: begin
                if (loop_q) state_nx = ST_HUNT;
            end
            ST_HUNT: begin
                if (!loop_q)       state_nx = ST_INTERNAL;
                else if (got_left) state_nx = ST_HAVE_LEFT;
            end
            ST_HAVE_LEFT: begin
                if (!loop_q)        state_nx = ST_INTERNAL;
                else if (got_right) state_nx = ST_HUNT;
            end
            default: state_nx = ST_INTERNAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_left  <= '0;
            conv_right <= '0;
            conv_valid <= 1'b0;
            left_hold  <= '0;
        end else begin
            conv_valid <= 1'b0;
            if (!loop_q) begin
                if (dec_valid && !cfg_err_q) begin
                    conv_left  <= dec_left;
                    conv_right <= dec_right;
                    conv_valid <= 1'b1;
                end
            end else begin
                unique case (state)
                    ST_HUNT, ST_HAVE_LEFT: begin
                        if (got_left) begin
                            left_hold <= word_data;
                        end else if (got_right && state == ST_HAVE_LEFT) begin
                            conv_left  <= left_hold;
                            conv_right <= word_data;
                            conv_valid <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/audio_src_router.sv
module audio_src_router
    import audio_route_pkg::*;
#(
    parameter int WORD_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           route_code,
    input  logic [3:0]           fmt_code,
    input  logic [WORD_BITS-1:0] dec_left,
    input  logic [WORD_BITS-1:0] dec_right,
    input  logic                 dec_valid,
    input  logic                 ser_bclk,
    input  logic                 ser_data,
    input  logic                 ser_wclk,
    output logic [WORD_BITS-1:0] conv_left,
    output logic [WORD_BITS-1:0] conv_right,
    output logic                 conv_valid,
    output logic                 ser_out_en,
    output logic                 cfg_err
);

    logic                 loop_q, style_i2s_q;
    logic                 rx_clear, word_done, word_left;
    logic [WORD_BITS-1:0] word_data;
    rtr_state_t           fsm_state;

    ars_route_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .route_code  (route_code),
        .fmt_code    (fmt_code),
        .loop_q      (loop_q),
        .style_i2s_q (style_i2s_q),
        .cfg_err_q   (cfg_err)
    );

    ars_serial_rx #(
        .WORD_BITS   (WORD_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .style_i2s (style_i2s_q),
        .ser_bclk  (ser_bclk),
        .ser_data  (ser_data),
        .ser_wclk  (ser_wclk),
        .word_done (word_done),
        .word_left (word_left),
        .word_data (word_data)
    );

    ars_frame_ctrl #(
        .WORD_BITS (WORD_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .loop_q     (loop_q),
        .cfg_err_q  (cfg_err),
        .dec_left   (dec_left),
        .dec_right  (dec_right),
        .dec_valid  (dec_valid),
        .word_done  (word_done),
        .word_left  (word_left),
        .word_data  (word_data),
        .conv_left  (conv_left),
        .conv_right (conv_right),
        .conv_valid (conv_valid),
        .rx_clear   (rx_clear),
        .state      (fsm_state)
    );

    assign ser_out_en = loop_q;

endmodule

// File: rtl/audio_src_router_chk.sv
module audio_src_router_chk
    import audio_route_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] route_code,
    input logic [3:0] fmt_code,
    input logic       dec_valid,
    input logic       conv_valid,
    input logic       ser_out_en,
    input logic       cfg_err,
    input logic [1:0] fsm_state
);

    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    assert_internal_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(ser_out_en)) |-> (conv_valid == ($past(dec_valid) && !$past(cfg_err))));

    assert_drive_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (ser_out_en == ($past(route_code) == ROUTE_LOOPBACK)));

    assert_cfg_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (cfg_err == (($past(route_code) != ROUTE_LOOPBACK) &&
                              !fmt_is_single_rate16($past(fmt_code)))));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live && conv_valid && $past(ser_out_en) && ser_out_en) |=> !conv_valid);

    assert_frame_after_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && conv_valid && $past(ser_out_en)) |-> ($past(fsm_state) == 2'(ST_HAVE_LEFT)));

endmodule

bind audio_src_router audio_src_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .route_code (route_code),
    .fmt_code   (fmt_code),
    .dec_valid  (dec_valid),
    .conv_valid (conv_valid),
    .ser_out_en (ser_out_en),
    .cfg_err    (cfg_err),
    .fsm_state  (fsm_state)
);

// File: tb/audio_src_router_tb_top.sv
module audio_src_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  route_code = 4'b0010;
    logic [3:0]  fmt_code = 4'b0010;
    logic [15:0] dec_left = '0, dec_right = '0;
    logic        dec_valid = 1'b0;
    logic        ser_bclk = 1'b0, ser_data = 1'b0, ser_wclk = 1'b0;
    logic [15:0] conv_left, conv_right;
    logic        conv_valid, ser_out_en, cfg_err;

    int checks = 0;
    int errors = 0;
    int pulse_total = 0;
    logic [15:0] cap_l [64];
    logic [15:0] cap_r [64];
    logic        prev_r0 = 1'b0;

    always #4 clk = ~clk;

    audio_src_router dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .route_code (route_code),
        .fmt_code   (fmt_code),
        .dec_left   (dec_left),
        .dec_right  (dec_right),
        .dec_valid  (dec_valid),
        .ser_bclk   (ser_bclk),
        .ser_data   (ser_data),
        .ser_wclk   (ser_wclk),
        .conv_left  (conv_left),
        .conv_right (conv_right),
        .conv_valid (conv_valid),
        .ser_out_en (ser_out_en),
        .cfg_err    (cfg_err)
    );

    always @(negedge clk) begin
        if (conv_valid) begin
            cap_l[pulse_total % 64] = conv_left;
            cap_r[pulse_total % 64] = conv_right;
            pulse_total = pulse_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected line values for rising edge i of a frame
    function automatic logic [1:0] edge_bits(input bit i2s, input int i, input logic [15:0] l,
                                             input logic [15:0] r, input logic pr0);
        logic wc, d;
        if (!i2s) begin
            wc = (i < 16);
            d  = (i < 16) ? l[15-i] : r[31-i];
        end else begin
            wc = (i >= 16);
            d  = (i == 0) ? pr0 : ((i <= 16) ? l[16-i] : r[32-i]);
        end
        return {wc, d};
    endfunction

    task automatic ser_edge(input logic [1:0] wd);
        @(negedge clk);
        ser_bclk = 1'b0;
        {ser_wclk, ser_data} = wd;
        repeat (3) @(negedge clk);
        ser_bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_edges(input bit i2s, input logic [15:0] l, input logic [15:0] r,
                              input int first, input int last);
        for (int i = first; i <= last; i++) ser_edge(edge_bits(i2s, i, l, r, prev_r0));
        if (last == 31) prev_r0 = r[0];
    endtask

    task automatic flush(input bit i2s);
        send_edges(i2s, 16'h0000, 16'h0000, 0, 0);
        repeat (12) @(negedge clk);
    endtask

    // partial frame from a random position, then nfull complete frames
    task automatic run_stream(input bit i2s, input int nfull, input string req);
        int base;
        int start;
        logic [15:0] el [8];
        logic [15:0] er [8];
        start = 2 + int'($urandom_range(0, 29));
        base  = pulse_total;
        send_edges(i2s, 16'($urandom), 16'($urandom), start, 31);
        for (int k = 0; k < nfull; k++) begin
            el[k] = 16'($urandom);
            er[k] = 16'($urandom);
            send_edges(i2s, el[k], er[k], 0, 31);
        end
        flush(i2s);
        check(pulse_total - base == nfull, {req, " frame count, partial dropped (R7)"},
              pulse_total - base, nfull);
        for (int k = 0; k < nfull; k++) begin
            check(cap_l[(base + k) % 64] == el[k], {req, " left word"}, cap_l[(base + k) % 64], el[k]);
            check(cap_r[(base + k) % 64] == er[k], {req, " right word"}, cap_r[(base + k) % 64], er[k]);
        end
    endtask

    task automatic dec_sample(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        dec_left = l; dec_right = r; dec_valid = 1'b1;
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (R6) actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] good_fmt [4];
        logic [3:0] bad_fmt [4];
        logic [3:0] rc;
        logic [15:0] l, r;
        int base;
        good_fmt = '{4'b1010, 4'b1011, 4'b1110, 4'b0010};
        bad_fmt  = '{4'b0000, 4'b0110, 4'b1111, 4'b0100};
        void'($urandom(32'd20251));

        repeat (3) @(negedge clk);
        check(conv_valid == 0 && conv_left == 0 && conv_right == 0, "R9 outputs in reset",
              {conv_valid, conv_left}, 0);
        check(ser_out_en == 0 && cfg_err == 0, "R9 flags in reset", {ser_out_en, cfg_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(conv_valid == 0 && ser_out_en == 0 && cfg_err == 0, "R9 after reset",
              {conv_valid, ser_out_en, cfg_err}, 0);

        // R1: internal routing under random codes and samples
        for (int n = 0; n < 20; n++) begin
            do rc = 4'($urandom); while (rc == 4'b0000);
            route_code = rc;
            fmt_code = good_fmt[$urandom_range(0, 3)];
            repeat (2) @(negedge clk);
            l = 16'($urandom); r = 16'($urandom);
            dec_left = l; dec_right = r; dec_valid = 1'b1;
            @(negedge clk);
            dec_valid = 1'b0;
            check(conv_valid && conv_left == l && conv_right == r, "R1 direct sample",
                  {conv_valid, conv_left}, {1'b1, l});
            check(ser_out_en == 0, "R1 outputs high impedance", ser_out_en, 0);
            @(negedge clk);
            check(conv_valid == 0, "R1 strobe length", conv_valid, 0);
        end

        // R4: incompatible formats with internal routing
        for (int n = 0; n < 4; n++) begin
            route_code = 4'b0010;
            fmt_code = bad_fmt[n];
            repeat (2) @(negedge clk);
            check(cfg_err == 1, "R4 error raised", cfg_err, 1);
            base = pulse_total;
            dec_sample(16'h1234, 16'h5678);
            repeat (2) @(negedge clk);
            check(pulse_total == base, "R4 samples blocked", pulse_total - base, 0);
        end
        route_code = 4'b0000;
        repeat (2) @(negedge clk);
        check(cfg_err == 0, "R4 no error in loopback", cfg_err, 0);

        // R3: serial activity ignored with internal routing
        route_code = 4'b0010;
        fmt_code = 4'b0010;
        repeat (2) @(negedge clk);
        base = pulse_total;
        for (int k = 0; k < 2; k++) send_edges(1'b0, 16'($urandom), 16'($urandom), 0, 31);
        flush(1'b0);
        check(pulse_total == base, "R3 serial ignored", pulse_total - base, 0);

        // R2: loopback enables drivers and ignores decoder samples
        route_code = 4'b0000;
        @(negedge clk);
        check(ser_out_en == 1, "R2 drivers enabled", ser_out_en, 1);
        base = pulse_total;
        dec_sample(16'hAAAA, 16'h5555);
        repeat (3) @(negedge clk);
        check(pulse_total == base, "R2 decoder ignored", pulse_total - base, 0);

        // R5/R6/R7: both framing styles from several format codes
        fmt_code = 4'b0010; @(negedge clk); run_stream(1'b0, 4, "R5 aligned");
        fmt_code = 4'b1110; @(negedge clk); run_stream(1'b1, 4, "R5 i2s");
        fmt_code = 4'b1011; @(negedge clk); run_stream(1'b0, 3, "R6 aligned cdrom");
        fmt_code = 4'b1010; @(negedge clk); run_stream(1'b1, 3, "R6 i2s cdrom");
        fmt_code = 4'b1100; @(negedge clk); run_stream(1'b1, 3, "R5 i2s wide output");
        fmt_code = 4'b0110; @(negedge clk); run_stream(1'b0, 3, "R5 aligned wide output");

        // R7: leave and re-enter loopback, then stream from mid-frame
        route_code = 4'b0010; repeat (3) @(negedge clk);
        route_code = 4'b0000; fmt_code = 4'b1110; repeat (3) @(negedge clk);
        run_stream(1'b1, 2, "R7 re-entry");

        // R8: truncated right word, next left replaces held left
        fmt_code = 4'b0010; @(negedge clk);
        base = pulse_total;
        send_edges(1'b0, 16'hDEAD, 16'hBEEF, 0, 23);
        l = 16'($urandom); r = 16'($urandom);
        send_edges(1'b0, l, r, 0, 31);
        flush(1'b0);
        check(pulse_total - base == 1, "R8 short frame dropped", pulse_total - base, 1);
        check(cap_l[base % 64] == l && cap_r[base % 64] == r, "R8 replaced left",
              cap_l[base % 64], l);
        repeat (20) @(negedge clk);
        check(conv_left == l && conv_right == r, "R6 samples held", conv_left, l);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule